// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator

This block converts a 31-bit virtual address into a 24-bit physical address. The upper 20 bits of the virtual address select a 2 KB page and the lower 11 bits give the byte offset within that page. The offset is passed through unchanged. A small fully associative translation cache maps the page to a 13-bit frame. If the page is in the cache, the physical address is returned in the cycle after the request is accepted.

When the page is not cached, the unit reads one page-table entry over a simple request/ready memory port. The entry's address is a page-table base input plus the page number. An entry that reports its page as absent ends the request with a fault indication and is not cached. An entry that reports its page as present is placed in the cache. If the cache is full, the least recently used slot is replaced. A write to a page whose modified flag is still clear makes the unit store the updated entry back to the page table, so that the page is written out later when it is evicted. A flush strobe empties the cache.

A requester raises `req_valid_i` while `busy_o` is low and then waits for the one-cycle `done_o` pulse. The result is read from `paddr_o` and `fault_o` in that same cycle.

Top module: `vaddr_xlat`

## Requirements
- R1: The physical address is {frame[12:0], offset[10:0]}, where the offset is bits [10:0] of the virtual address and the page number is bits [30:11].
- R2: A request whose page is held in the translation cache finishes with `done_o` in the first cycle after the accepting edge, and it causes no page-table access.
- R3: On a cache miss the unit raises `pt_req_o` with `pt_we_o` low at address `pt_base_i` + page number. It holds the address steady until it samples `pt_ready_i` high.
- R4: A page-table entry is 16 bits: frame in [12:0], present in bit 13, modified in bit 14, referenced in bit 15. If the entry read has the present bit clear, the request ends with `fault_o` and `done_o` high and `paddr_o` equal to zero. The entry is not cached, so a repeat access walks the table again.
- R5: An entry read with the present bit set is cached, and a later access to the same page hits.
- R6: The cache holds 8 pages at once. When all 8 slots are valid, a refill evicts the least recently used page.
- R7: One cycle of `flush_i` invalidates every cached page, so the next access to any page walks the table.
- R8: A write (`req_write_i`=1) to a page whose modified bit is clear issues exactly one page-table write to the same entry address. The written entry keeps the same frame, present and referenced bits and has the modified bit set. A second write to that page issues no further write.
- R9: Reads never write the page table. A write to a page whose entry already has the modified bit set writes nothing either.
- R10: After reset, `busy_o`, `done_o` and `pt_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all cached translations |
| req_valid_i | input | 1 | Translation request, accepted while `busy_o` is low |
| req_write_i | input | 1 | Request is a write access |
| req_vaddr_i | input | 31 | Virtual address |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Completion is a page fault |
| paddr_o | output | 24 | Physical address, valid with `done_o` |
| pt_base_i | input | 24 | Page-table base address |
| pt_req_o | output | 1 | Page-table access request |
| pt_we_o | output | 1 | Page-table access is a write |
| pt_addr_o | output | 24 | Page-table entry address |
| pt_wdata_o | output | 16 | Entry written back |
| pt_rdata_i | input | 16 | Entry read |
| pt_ready_i | input | 1 | Page-table access completes this cycle |

## Verification
The bench builds the block with its default values: 31-bit virtual and 24-bit physical addresses, 2 KB pages and 8 cache slots. With only 8 slots, nine distinct pages are enough to fill the cache and force an eviction. That makes the least-recently-used choice visible through the page-table read count. The page-table model answers each access two cycles after the request. This exercises the hold-until-ready behaviour on both reads and write-backs. The model keeps one page absent and one page pre-marked modified, so that the fault path and both sides of the write-back rule are reached.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    // control bits sit directly above the frame number in a table entry
    localparam int CTRL_W  = 3;
    localparam int CB_PRES = 0;
    localparam int CB_MOD  = 1;
    localparam int CB_REF  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_WBACK = 2'd2
    } xlat_state_e;
endpackage

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    output logic [IDX_W-1:0] oldest_o
);
    // each slot carries a recency rank; 0 = newest, ENTRIES-1 = oldest
    logic [IDX_W-1:0] age_d [ENTRIES];
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [ENTRIES-1:0] oldest_vec;

    always_comb begin
        for (int j = 0; j < ENTRIES; j++) begin
            age_d[j] = age_q[j];
            if (touch_en_i) begin
                if (IDX_W'(j) == touch_idx_i)
                    age_d[j] = '0;
                else if (age_q[j] < age_q[touch_idx_i])
                    age_d[j] = age_q[j] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < ENTRIES; j++)
            age_q[j] <= rst_n ? age_d[j] : IDX_W'(j);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        oldest_o = '0;
        for (int j = ENTRIES - 1; j >= 0; j--)
            if (oldest_vec[j]) oldest_o = IDX_W'(j);
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1); // R6
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int ENTRIES = 8,
    parameter int PAGE_W  = 20,
    parameter int PTE_W   = 16,
    parameter int MOD_BIT = 14,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [PAGE_W-1:0] lk_page_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  hit_idx_o,
    output logic [PTE_W-1:0]  hit_pte_o,
    input  logic              touch_en_i,
    input  logic [IDX_W-1:0]  touch_idx_i,
    input  logic              fill_en_i,
    input  logic [PAGE_W-1:0] fill_page_i,
    input  logic [PTE_W-1:0]  fill_pte_i,
    input  logic              setmod_en_i,
    input  logic [IDX_W-1:0]  setmod_idx_i
);
    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [PAGE_W-1:0]  page_d [ENTRIES];
    logic [PAGE_W-1:0]  page_q [ENTRIES];
    logic [PTE_W-1:0]   pte_d  [ENTRIES];
    logic [PTE_W-1:0]   pte_q  [ENTRIES];
    logic [ENTRIES-1:0] match_vec;
    logic [IDX_W-1:0]   oldest, victim;
    logic               any_free;
    logic [IDX_W-1:0]   free_idx;
    logic               lru_touch;
    logic [IDX_W-1:0]   lru_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (page_q[g] == lk_page_i);
    end

    always_comb begin
        hit_o     = |match_vec;
        hit_idx_o = '0;
        hit_pte_o = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (match_vec[j]) begin
                hit_idx_o = IDX_W'(j);
                hit_pte_o = pte_q[j];
            end
        end
    end

    // lowest empty slot first, otherwise the least recently used one
    always_comb begin
        any_free = ~&valid_q;
        free_idx = '0;
        for (int j = ENTRIES - 1; j >= 0; j--)
            if (!valid_q[j]) free_idx = IDX_W'(j);
        victim = any_free ? free_idx : oldest;
    end

    always_comb begin
        valid_d = valid_q;
        for (int j = 0; j < ENTRIES; j++) begin
            page_d[j] = page_q[j];
            pte_d[j]  = pte_q[j];
        end
        if (setmod_en_i)
            pte_d[setmod_idx_i][MOD_BIT] = 1'b1;
        if (fill_en_i) begin
            valid_d[victim] = 1'b1;
            page_d[victim]  = fill_page_i;
            pte_d[victim]   = fill_pte_i;
        end
        if (flush_i)
            valid_d = '0;
    end

    always_ff @(posedge clk) begin
        valid_q <= rst_n ? valid_d : '0;
        for (int j = 0; j < ENTRIES; j++) begin
            page_q[j] <= page_d[j];
            pte_q[j]  <= pte_d[j];
        end
    end

    assign lru_touch = touch_en_i || fill_en_i;
    assign lru_idx   = fill_en_i ? victim : touch_idx_i;

    xlat_lru #(.ENTRIES(ENTRIES)) i_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en_i (lru_touch),
        .touch_idx_i(lru_idx),
        .oldest_o   (oldest)
    );

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !hit_o); // R7
endmodule

// File: rtl/vaddr_xlat.sv
module vaddr_xlat
    import xlat_pkg::*;
#(
    parameter int VA_W    = 31,
    parameter int OFF_W   = 11,
    parameter int PA_W    = 24,
    parameter int PT_AW   = 24,
    parameter int ENTRIES = 8,
    localparam int PAGE_W   = VA_W - OFF_W,
    localparam int FRAME_W  = PA_W - OFF_W,
    localparam int PTE_W    = FRAME_W + CTRL_W,
    localparam int PRES_BIT = FRAME_W + CB_PRES,
    localparam int MOD_BIT  = FRAME_W + CB_MOD,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fault_o,
    output logic [PA_W-1:0]  paddr_o,
    input  logic [PT_AW-1:0] pt_base_i,
    output logic             pt_req_o,
    output logic             pt_we_o,
    output logic [PT_AW-1:0] pt_addr_o,
    output logic [PTE_W-1:0] pt_wdata_o,
    input  logic [PTE_W-1:0] pt_rdata_i,
    input  logic             pt_ready_i
);
    typedef struct packed {
        xlat_state_e       st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic              wr;
        logic [PTE_W-1:0]  pte;
        logic              done;
        logic              fault;
        logic [PA_W-1:0]   paddr;
    } regs_t;

    regs_t r_d, r_q;

    logic [PAGE_W-1:0] lk_page;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [PTE_W-1:0]  hit_pte;
    logic              touch_en, fill_en, setmod_en;
    logic [PTE_W-1:0]  fill_pte;

    assign lk_page = req_vaddr_i[VA_W-1:OFF_W];

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        touch_en  = 1'b0;
        fill_en   = 1'b0;
        setmod_en = 1'b0;
        fill_pte  = pt_rdata_i;
        pt_req_o  = 1'b0;
        pt_we_o   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.page = lk_page;
                    r_d.off  = req_vaddr_i[OFF_W-1:0];
                    r_d.wr   = req_write_i;
                    if (hit) begin
                        touch_en = 1'b1;
                        r_d.pte  = hit_pte;
                        if (req_write_i && !hit_pte[MOD_BIT]) begin
                            setmod_en        = 1'b1;
                            r_d.pte[MOD_BIT] = 1'b1;
                            r_d.st           = ST_WBACK;
                        end else begin
                            r_d.done  = 1'b1;
                            r_d.paddr = {hit_pte[FRAME_W-1:0], req_vaddr_i[OFF_W-1:0]};
                        end
                    end else begin
                        r_d.st = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                pt_req_o = 1'b1;
                if (pt_ready_i) begin
                    if (!pt_rdata_i[PRES_BIT]) begin
                        r_d.done  = 1'b1;
                        r_d.fault = 1'b1;
                        r_d.paddr = '0;
                        r_d.st    = ST_IDLE;
                    end else begin
                        fill_en           = 1'b1;
                        fill_pte[MOD_BIT] = pt_rdata_i[MOD_BIT] | r_q.wr;
                        r_d.pte           = fill_pte;
                        if (r_q.wr && !pt_rdata_i[MOD_BIT]) begin
                            r_d.st = ST_WBACK;
                        end else begin
                            r_d.done  = 1'b1;
                            r_d.paddr = {pt_rdata_i[FRAME_W-1:0], r_q.off};
                            r_d.st    = ST_IDLE;
                        end
                    end
                end
            end
            ST_WBACK: begin
                pt_req_o = 1'b1;
                pt_we_o  = 1'b1;
                if (pt_ready_i) begin
                    r_d.done  = 1'b1;
                    r_d.paddr = {r_q.pte[FRAME_W-1:0], r_q.off};
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign fault_o    = r_q.fault;
    assign paddr_o    = r_q.paddr;
    assign pt_addr_o  = pt_base_i + PT_AW'(r_q.page);
    assign pt_wdata_o = r_q.pte;

    xlat_tlb #(
        .ENTRIES(ENTRIES),
        .PAGE_W (PAGE_W),
        .PTE_W  (PTE_W),
        .MOD_BIT(MOD_BIT)
    ) i_tlb (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .lk_page_i   (lk_page),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx),
        .hit_pte_o   (hit_pte),
        .touch_en_i  (touch_en),
        .touch_idx_i (hit_idx),
        .fill_en_i   (fill_en),
        .fill_page_i (r_q.page),
        .fill_pte_i  (fill_pte),
        .setmod_en_i (setmod_en),
        .setmod_idx_i(hit_idx)
    );

    AST_PT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req_o && !pt_ready_i) |=> (pt_req_o && $stable(pt_addr_o) && $stable(pt_we_o))); // R3
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pt_req_o); // R2
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (done_o && paddr_o == '0)); // R4
    AST_WB_MODSET: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req_o && pt_we_o) |-> (pt_wdata_o[MOD_BIT] && pt_wdata_o[PRES_BIT])); // R8
endmodule

// File: tb/test_vaddr_xlat.sv
`timescale 1ns/1ps
module test_vaddr_xlat;
    localparam logic [23:0] BASE = 24'h10_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [30:0] req_vaddr_i = '0;
    logic        busy_o, done_o, fault_o;
    logic [23:0] paddr_o;
    logic        pt_req_o, pt_we_o;
    logic [23:0] pt_addr_o;
    logic [15:0] pt_wdata_o, pt_rdata_i;
    logic        pt_ready_i = 1'b0;

    logic [15:0] ptmem [64];
    int          n_reads = 0, n_writes = 0;
    logic [23:0] last_raddr = '0, last_waddr = '0;
    logic [15:0] last_wdata = '0;
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    vaddr_xlat i_vaddr_xlat (
        .clk, .rst_n, .flush_i, .req_valid_i, .req_write_i, .req_vaddr_i,
        .busy_o, .done_o, .fault_o, .paddr_o,
        .pt_base_i(BASE), .pt_req_o, .pt_we_o, .pt_addr_o, .pt_wdata_o,
        .pt_rdata_i, .pt_ready_i
    );

    // entry layout: frame [12:0], present 13, modified 14, referenced 15 (R4)
    function automatic logic [15:0] pte_of(int p);
        logic [12:0] fr = 13'(p * 37 + 5);
        return {p[0], (p == 60), (p != 50), fr};
    endfunction

    assign pt_rdata_i = ptmem[6'(pt_addr_o - BASE)];

    // page-table model answering every access two cycles after the request
    initial begin
        int wait_cnt = 0;
        for (int i = 0; i < 64; i++) ptmem[i] = pte_of(i);
        forever begin
            @(negedge clk);
            pt_ready_i = 1'b0;
            if (pt_req_o) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    wait_cnt   = 0;
                    pt_ready_i = 1'b1;
                    if (pt_we_o) begin
                        n_writes++;
                        last_waddr = pt_addr_o;
                        last_wdata = pt_wdata_o;
                        ptmem[6'(pt_addr_o - BASE)] = pt_wdata_o;
                    end else begin
                        n_reads++;
                        last_raddr = pt_addr_o;
                    end
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input int page, input logic [10:0] off, input bit wr,
                          output int cyc, output bit flt, output logic [23:0] pa);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_write_i = wr;
        req_vaddr_i = {20'(page), off};
        @(negedge clk);
        req_valid_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        flt = fault_o;
        pa  = paddr_o;
        if (!done_o) begin
            errors++;
            checks++;
            $display("FAIL R2 request timeout actual=%0d expected=done", cyc);
        end
    endtask

    function automatic logic [23:0] exp_pa(int p, logic [10:0] off);
        return {pte_of(p)[12:0], off};
    endfunction

    task automatic t_reset();
        check(!busy_o, "R10 busy", 32'(busy_o), 0);
        check(!done_o, "R10 done", 32'(done_o), 0);
        check(!pt_req_o, "R10 pt_req", 32'(pt_req_o), 0);
    endtask

    task automatic t_miss_hit();
        int c; bit f; logic [23:0] pa; int r0;
        r0 = n_reads;
        access(3, 11'h7AB, 0, c, f, pa);
        check(n_reads == r0 + 1, "R3 miss reads once", 32'(n_reads - r0), 1);
        check(last_raddr == BASE + 24'd3, "R3 entry address", 32'(last_raddr), 32'(BASE + 24'd3));
        check(pa == exp_pa(3, 11'h7AB) && !f, "R1 paddr after walk", 32'(pa), 32'(exp_pa(3, 11'h7AB)));
        r0 = n_reads;
        access(3, 11'h012, 0, c, f, pa);
        check(n_reads == r0, "R5 repeat hits", 32'(n_reads - r0), 0);
        check(c == 1, "R2 hit latency", 32'(c), 1);
        check(pa == exp_pa(3, 11'h012), "R1 paddr on hit", 32'(pa), 32'(exp_pa(3, 11'h012)));
    endtask

    task automatic t_fault();
        int c; bit f; logic [23:0] pa; int r0;
        r0 = n_reads;
        access(50, 11'h055, 0, c, f, pa);
        check(f == 1'b1, "R4 fault raised", 32'(f), 1);
        check(pa == '0, "R4 paddr zero", 32'(pa), 0);
        access(50, 11'h055, 0, c, f, pa);
        check(n_reads == r0 + 2 && f, "R4 not cached", 32'(n_reads - r0), 2);
    endtask

    task automatic t_writeback();
        int c; bit f; logic [23:0] pa; int w0;
        logic [15:0] exp_e;
        access(4, 11'h100, 0, c, f, pa);
        w0 = n_writes;
        access(4, 11'h101, 1, c, f, pa);
        exp_e = pte_of(4) | 16'h4000;
        check(n_writes == w0 + 1, "R8 one write-back", 32'(n_writes - w0), 1);
        check(last_waddr == BASE + 24'd4, "R8 write address", 32'(last_waddr), 32'(BASE + 24'd4));
        check(last_wdata == exp_e, "R8 written entry", 32'(last_wdata), 32'(exp_e));
        check(pa == exp_pa(4, 11'h101), "R1 paddr after write-back", 32'(pa), 32'(exp_pa(4, 11'h101)));
        w0 = n_writes;
        access(4, 11'h102, 1, c, f, pa);
        check(n_writes == w0 && c == 1, "R8 second write quiet", 32'(n_writes - w0), 0);
        access(7, 11'h000, 0, c, f, pa);
        check(n_writes == w0, "R9 read never writes", 32'(n_writes - w0), 0);
        access(60, 11'h3FF, 1, c, f, pa);
        check(n_writes == w0, "R9 already modified", 32'(n_writes - w0), 0);
        access(21, 11'h001, 1, c, f, pa);
        exp_e = pte_of(21) | 16'h4000;
        check(n_writes == w0 + 1 && last_wdata == exp_e, "R8 write miss write-back",
              32'(last_wdata), 32'(exp_e));
    endtask

    task automatic t_flush();
        int c; bit f; logic [23:0] pa; int r0;
        access(3, 11'h0, 0, c, f, pa);
        @(negedge clk) flush_i = 1'b1;
        @(negedge clk) flush_i = 1'b0;
        r0 = n_reads;
        access(3, 11'h0, 0, c, f, pa);
        check(n_reads == r0 + 1, "R7 flush forces walk", 32'(n_reads - r0), 1);
    endtask

    task automatic t_lru();
        int c; bit f; logic [23:0] pa; int r0;
        @(negedge clk) flush_i = 1'b1;
        @(negedge clk) flush_i = 1'b0;
        for (int p = 10; p < 18; p++) access(p, 11'h0, 0, c, f, pa);
        r0 = n_reads;
        for (int p = 10; p < 18; p++) access(p, 11'h0, 0, c, f, pa);
        check(n_reads == r0, "R6 eight pages resident", 32'(n_reads - r0), 0);
        access(10, 11'h0, 0, c, f, pa);
        access(18, 11'h0, 0, c, f, pa);
        check(n_reads == r0 + 1, "R6 refill walks", 32'(n_reads - r0), 1);
        access(10, 11'h0, 0, c, f, pa);
        check(n_reads == r0 + 1, "R6 recent page kept", 32'(n_reads - r0), 1);
        access(11, 11'h0, 0, c, f, pa);
        check(n_reads == r0 + 2, "R6 oldest page evicted", 32'(n_reads - r0), 2);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_miss_hit();
        t_fault();
        t_writeback();
        t_flush();
        t_lru();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule